// File: doc/BRIEF.md
# ECC Error Capture and Reporting

This block sits next to the SECDED check unit on a memory read path. For each read the check unit can pulse one strobe for a corrected single-bit error and another for an uncorrectable multi-bit error, and it supplies the failing address and the 8-bit syndrome alongside. The block records only the first error in one 32-bit error-pointer register. Software reads that register and writes it back through a simple register port.

From the logged state and the enable bits held in the same register, the block drives two level outputs: a non-maskable interrupt request for corrected errors and a bus-error line for uncorrectable ones. After every corrected read it raises a one-cycle scrub request, so that the corrected word is written back to memory. A separate test input forces the outgoing check bits on write cycles to zero, which lets software inject errors.

The register layout is fixed because software decodes it. Bit 0 is the corrected flag and bit 1 is the uncorrectable flag. Bit 2 enables the interrupt and bit 3 enables the bus-error line. Bits 11:4 hold the syndrome, bits 30:12 hold the upper 19 bits of the failing address, and bit 31 disables the scrub write-back.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset the register reads 0x0000_0000, and `nmi_req`, `bus_err` and `scrub_req` are low.
- R2: With `ecc_en` high and both flags clear, a strobe captures an error on the next clock edge. `ce_stb` sets bit 0 and `ue_stb` sets bit 1; if both strobes come in the same cycle, only bit 1 is set. The same edge loads `err_addr[30:12]` into bits 30:12 and `err_syn` into bits 11:4. While either flag is set, later strobes change neither the flags nor bits 30:4, and the two flags never read 1 together.
- R3: A register write with data bits 1:0 = 2'b11 clears both flags. A write with bits 1:0 equal to 00, 01 or 10 leaves the flags, the address and the syndrome unchanged.
- R4: When a clearing write and a strobe arrive in the same cycle, the clear wins and the event is dropped. Both flags then read 0.
- R5: Every register write loads bits 31, 3 and 2 from the write data, and they read back unchanged. Writes never alter bits 30:4.
- R6: `scrub_req` is high for exactly the one cycle after a cycle in which `ce_stb` is high, `ecc_en` is high and bit 31 is 0. This happens whether or not the error is logged. It stays low after a `ue_stb` alone, and whenever bit 31 is 1.
- R7: `nmi_req` is high exactly when bit 0 and bit 2 are both 1.
- R8: `bus_err` is high exactly when bit 1 and bit 3 are both 1.
- R9: `wr_chk_out` equals `wr_chk_in` while `force_zero` is low, and is all zeros while `force_zero` is high. The path is combinational.
- R10: While `ecc_en` is low, strobes set no flag and raise no `scrub_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Global ECC checking and reporting enable |
| force_zero | input | 1 | Test mode: drive write check bits to zero |
| ce_stb | input | 1 | Corrected single-bit error on this read |
| ue_stb | input | 1 | Uncorrectable multi-bit error on this read |
| err_addr | input | ADDR_W (31) | Failing read address |
| err_syn | input | 8 | Syndrome of the failing read |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Error-pointer register contents |
| wr_chk_in | input | CHK_W (8) | Check bits from the encoder for a write |
| wr_chk_out | output | CHK_W (8) | Check bits sent to memory |
| nmi_req | output | 1 | Interrupt request for a logged corrected error |
| bus_err | output | 1 | Bus-error signal for a logged uncorrectable error |
| scrub_req | output | 1 | One-cycle request to write back corrected data |

## Verification
The hardest cases to reach from the ports are two collisions. One is a clearing write that lands in the same cycle as a new strobe. The other is a strobe of the opposite type that arrives while an error is already held. The bench drives both strobes and the register write from a single per-cycle task, so it can place any mix of them on one edge. It then compares the full register image against a value packed arithmetically from the inputs. Sweeps over all 256 syndromes, a walking one over the 19 captured address bits, and every enable combination for both error types show which fields moved and which did not.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int REG_W         = 32;
  localparam int SYN_W         = 8;
  localparam int PTR_W         = 19;
  localparam int CE_BIT        = 0;
  localparam int UE_BIT        = 1;
  localparam int NMI_EN_BIT    = 2;
  localparam int BERR_EN_BIT   = 3;
  localparam int SYN_LSB       = 4;
  localparam int PTR_LSB       = SYN_LSB + SYN_W;
  localparam int SCRUB_DIS_BIT = PTR_LSB + PTR_W;

  typedef struct packed {
    logic scrub_dis;
    logic berr_en;
    logic nmi_en;
  } log_ctrl_t;

  typedef struct packed {
    logic [PTR_W-1:0] ptr;
    logic [SYN_W-1:0] syn;
    logic             ue;
    logic             ce;
  } log_stat_t;
endpackage

// File: rtl/ecc_log_status.sv
module ecc_log_status
  import ecc_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ecc_en,
  input  logic             ce_stb,
  input  logic             ue_stb,
  input  logic [PTR_W-1:0] addr_hi,
  input  logic [SYN_W-1:0] syn_in,
  input  logic             clr_req,
  output log_stat_t        stat_q
);
  log_stat_t stat_n;
  logic      logged;
  logic      take;
  logic      upd;

  always_comb begin
    logged = stat_q.ce | stat_q.ue;
    take   = ecc_en & (ce_stb | ue_stb) & ~logged & ~clr_req;
    upd    = clr_req | take;
    stat_n = stat_q;
    if (clr_req) begin
      stat_n.ce = 1'b0;
      stat_n.ue = 1'b0;
    end else if (take) begin
      stat_n.ue  = ue_stb;
      stat_n.ce  = ~ue_stb;
      stat_n.ptr = addr_hi;
      stat_n.syn = syn_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (upd) begin
      stat_q <= stat_n;
    end
  end
endmodule

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  log_ctrl_t ctrl_in,
  output log_ctrl_t ctrl_q
);
  log_ctrl_t ctrl_n;

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_en) ctrl_n = ctrl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_n;
    end
  end
endmodule

// File: rtl/ecc_log_signal.sv
module ecc_log_signal
  import ecc_log_pkg::*;
#(
  parameter int CHK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ecc_en,
  input  logic             ce_stb,
  input  log_ctrl_t        ctrl,
  input  log_stat_t        stat,
  input  logic             force_zero,
  input  logic [CHK_W-1:0] chk_in,
  output logic [CHK_W-1:0] chk_out,
  output logic             nmi,
  output logic             berr,
  output logic             scrub
);
  logic scrub_n;

  always_comb begin
    scrub_n = ecc_en & ce_stb & ~ctrl.scrub_dis;
    nmi     = stat.ce & ctrl.nmi_en;
    berr    = stat.ue & ctrl.berr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scrub <= 1'b0;
    end else begin
      scrub <= scrub_n;
    end
  end

  for (genvar i = 0; i < CHK_W; i++) begin : g_chk
    assign chk_out[i] = chk_in[i] & ~force_zero;
  end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 31,
  parameter int CHK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_en,
  input  logic              force_zero,
  input  logic              ce_stb,
  input  logic              ue_stb,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [CHK_W-1:0]  wr_chk_in,
  output logic [CHK_W-1:0]  wr_chk_out,
  output logic              nmi_req,
  output logic              bus_err,
  output logic              scrub_req
);
  localparam int ADDR_LSB = ADDR_W - PTR_W;

  log_stat_t stat;
  log_ctrl_t ctrl;
  log_ctrl_t ctrl_wr;
  logic      clr_req;
  logic      unused_addr;
  logic      unused_wdata;

  assign unused_addr  = ^err_addr[ADDR_LSB-1:0];
  assign unused_wdata = ^reg_wdata[SCRUB_DIS_BIT-1:SYN_LSB];

  assign clr_req = reg_wr & reg_wdata[CE_BIT] & reg_wdata[UE_BIT];

  assign ctrl_wr.scrub_dis = reg_wdata[SCRUB_DIS_BIT];
  assign ctrl_wr.berr_en   = reg_wdata[BERR_EN_BIT];
  assign ctrl_wr.nmi_en    = reg_wdata[NMI_EN_BIT];

  ecc_log_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .ecc_en  (ecc_en),
    .ce_stb  (ce_stb),
    .ue_stb  (ue_stb),
    .addr_hi (err_addr[ADDR_W-1:ADDR_LSB]),
    .syn_in  (err_syn),
    .clr_req (clr_req),
    .stat_q  (stat)
  );

  ecc_log_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .ctrl_in (ctrl_wr),
    .ctrl_q  (ctrl)
  );

  ecc_log_signal #(.CHK_W(CHK_W)) u_signal (
    .clk        (clk),
    .rst_n      (rst_n),
    .ecc_en     (ecc_en),
    .ce_stb     (ce_stb),
    .ctrl       (ctrl),
    .stat       (stat),
    .force_zero (force_zero),
    .chk_in     (wr_chk_in),
    .chk_out    (wr_chk_out),
    .nmi        (nmi_req),
    .berr       (bus_err),
    .scrub      (scrub_req)
  );

  always_comb begin
    reg_rdata                                = '0;
    reg_rdata[CE_BIT]                        = stat.ce;
    reg_rdata[UE_BIT]                        = stat.ue;
    reg_rdata[NMI_EN_BIT]                    = ctrl.nmi_en;
    reg_rdata[BERR_EN_BIT]                   = ctrl.berr_en;
    reg_rdata[SYN_LSB +: SYN_W]              = stat.syn;
    reg_rdata[PTR_LSB +: PTR_W]              = stat.ptr;
    reg_rdata[SCRUB_DIS_BIT]                 = ctrl.scrub_dis;
  end
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk #(
  parameter int CHK_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ecc_en,
  input logic             force_zero,
  input logic             ce_stb,
  input logic             ue_stb,
  input logic             reg_wr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic [CHK_W-1:0] wr_chk_out,
  input logic             nmi_req,
  input logic             bus_err,
  input logic             scrub_req
);
  logic wr_clear;
  assign wr_clear = reg_wr & reg_wdata[1] & reg_wdata[0];

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[1:0] != 2'b11); // R2
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1:0] != 2'b00) && !wr_clear |=> $stable(reg_rdata[30:4]) && $stable(reg_rdata[1:0])); // R2
  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> reg_rdata[1:0] == 2'b00); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear && (ce_stb || ue_stb) |=> reg_rdata[1:0] == 2'b00); // R4
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[31] == $past(reg_wdata[31]) && reg_rdata[3:2] == $past(reg_wdata[3:2])); // R5
  AST_SCRUB_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ce_stb && ecc_en && !reg_rdata[31] |=> scrub_req); // R6
  AST_SCRUB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce_stb && ecc_en && !reg_rdata[31]) |=> !scrub_req); // R6
  AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == (reg_rdata[0] && reg_rdata[2])); // R7
  AST_BERR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err == (reg_rdata[1] && reg_rdata[3])); // R8
  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    force_zero |-> wr_chk_out == '0); // R9
  AST_ECC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_en && reg_rdata[1:0] == 2'b00 |=> reg_rdata[1:0] == 2'b00); // R10
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.CHK_W(CHK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ecc_en     (ecc_en),
  .force_zero (force_zero),
  .ce_stb     (ce_stb),
  .ue_stb     (ue_stb),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .wr_chk_out (wr_chk_out),
  .nmi_req    (nmi_req),
  .bus_err    (bus_err),
  .scrub_req  (scrub_req)
);

// File: tb/ecc_err_logger_bench.sv
module ecc_err_logger_bench;
  logic        clk;
  logic        rst_n;
  logic        ecc_en;
  logic        force_zero;
  logic        ce_stb;
  logic        ue_stb;
  logic [30:0] err_addr;
  logic [7:0]  err_syn;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  wr_chk_in;
  logic [7:0]  wr_chk_out;
  logic        nmi_req;
  logic        bus_err;
  logic        scrub_req;

  int n_chk;
  int n_err;
  bit done;

  ecc_err_logger u_ecc_err_logger (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .force_zero(force_zero),
    .ce_stb(ce_stb), .ue_stb(ue_stb), .err_addr(err_addr), .err_syn(err_syn),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wr_chk_in(wr_chk_in), .wr_chk_out(wr_chk_out),
    .nmi_req(nmi_req), .bus_err(bus_err), .scrub_req(scrub_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] img(input logic sd, input logic [18:0] p,
                                      input logic [7:0] s, input logic be,
                                      input logic ne, input logic ue, input logic ce);
    return {sd, p, s, be, ne, ue, ce};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [31:0] wd, input logic ce,
                     input logic ue, input logic [30:0] a, input logic [7:0] s);
    @(negedge clk);
    reg_wr = wr; reg_wdata = wd; ce_stb = ce; ue_stb = ue; err_addr = a; err_syn = s;
    @(negedge clk);
    reg_wr = 1'b0; ce_stb = 1'b0; ue_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [30:0] a;
    logic [31:0] held;
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; ecc_en = 1'b0; force_zero = 1'b0; ce_stb = 1'b0; ue_stb = 1'b0;
    err_addr = '0; err_syn = '0; reg_wr = 1'b0; reg_wdata = '0; wr_chk_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 outs", {29'd0, nmi_req, bus_err, scrub_req}, 32'h0);

    // R10: strobes ignored while ECC disabled
    cyc(1'b0, 0, 1'b1, 1'b0, 31'h7FFF_FFFF, 8'hAA);
    check("R10 ce ignored", reg_rdata, 32'h0);
    check("R10 no scrub", {31'd0, scrub_req}, 32'h0);
    cyc(1'b0, 0, 1'b0, 1'b1, 31'h7FFF_FFFF, 8'h55);
    check("R10 ue ignored", reg_rdata, 32'h0);

    ecc_en = 1'b1;
    // R2 / R6: full syndrome sweep with corrected errors, then clear (R3)
    for (int s = 0; s < 256; s++) begin
      a = 31'(s * 32'h0001_3579 + 32'h123);
      cyc(1'b0, 0, 1'b1, 1'b0, a, 8'(s));
      check("R2 ce capture", reg_rdata, img(1'b0, a[30:12], 8'(s), 1'b0, 1'b0, 1'b0, 1'b1));
      check("R6 scrub pulse", {31'd0, scrub_req}, 32'h1);
      cyc(1'b1, 32'h3, 1'b0, 1'b0, a, 8'(s));
      check("R3 clear", reg_rdata, img(1'b0, a[30:12], 8'(s), 1'b0, 1'b0, 1'b0, 1'b0));
      check("R6 scrub one cycle", {31'd0, scrub_req}, 32'h0);
    end

    // R2 / R6: walking one over captured address bits with uncorrectable errors
    for (int b = 0; b < 19; b++) begin
      a = 31'(1) << (b + 12);
      cyc(1'b0, 0, 1'b0, 1'b1, a | 31'hFFF, 8'(b));
      check("R2 ue capture", reg_rdata, img(1'b0, a[30:12], 8'(b), 1'b0, 1'b0, 1'b1, 1'b0));
      check("R6 no scrub on ue", {31'd0, scrub_req}, 32'h0);
      cyc(1'b1, 32'h3, 1'b0, 1'b0, '0, '0);
    end

    // R2: both strobes together log only the uncorrectable flag
    cyc(1'b0, 0, 1'b1, 1'b1, 31'h4000_5000, 8'h3C);
    check("R2 both strobes", reg_rdata, img(1'b0, 19'h40005, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0));
    cyc(1'b1, 32'h3, 1'b0, 1'b0, '0, '0);

    // R2: only the first error held
    cyc(1'b0, 0, 1'b1, 1'b0, 31'h1111_1000, 8'h11);
    held = reg_rdata;
    cyc(1'b0, 0, 1'b0, 1'b1, 31'h2222_2000, 8'h22);
    check("R2 later ue ignored", reg_rdata, held);
    cyc(1'b0, 0, 1'b1, 1'b0, 31'h3333_3000, 8'h33);
    check("R2 later ce ignored", reg_rdata, held);

    // R3 / R5: partial clears keep status; control bits load; RO bits untouched
    for (int w = 0; w < 3; w++) begin
      cyc(1'b1, 32'h7FFF_FFF0 | 32'(w) | (32'(w) << 2) | (32'(w & 1) << 31), 1'b0, 1'b0, '0, '0);
      check("R3 partial write", reg_rdata,
            img(1'((w & 1) != 0), held[30:12], held[11:4], 1'((w & 2) != 0), 1'((w & 1) != 0), 1'b0, 1'b1));
    end
    cyc(1'b1, 32'h3, 1'b0, 1'b0, '0, '0);
    check("R5 control cleared", reg_rdata, img(1'b0, held[30:12], held[11:4], 1'b0, 1'b0, 1'b0, 1'b0));

    // R4: clear and event in the same cycle
    cyc(1'b0, 0, 1'b0, 1'b1, 31'h0ABC_D000, 8'h77);
    cyc(1'b1, 32'h3, 1'b1, 1'b0, 31'h0123_4000, 8'h99);
    check("R4 clear wins", reg_rdata, img(1'b0, 19'h0ABCD, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    check("R4 event dropped", reg_rdata, img(1'b0, 19'h0ABCD, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0));

    // R7 / R8: every enable pair for both error types
    for (int e = 0; e < 4; e++) begin
      for (int t = 0; t < 2; t++) begin
        cyc(1'b1, 32'(e) << 2, 1'b0, 1'b0, '0, '0);
        cyc(1'b0, 0, 1'(t == 0), 1'(t == 1), 31'h5555_5000, 8'h5A);
        check("R7 nmi level", {31'd0, nmi_req}, 32'((t == 0) && ((e & 1) != 0)));
        check("R8 berr level", {31'd0, bus_err}, 32'((t == 1) && ((e & 2) != 0)));
        @(negedge clk);
        check("R7 nmi held", {31'd0, nmi_req}, 32'((t == 0) && ((e & 1) != 0)));
        cyc(1'b1, (32'(e) << 2) | 32'h3, 1'b0, 1'b0, '0, '0);
        check("R8 levels drop", {30'd0, nmi_req, bus_err}, 32'h0);
      end
    end

    // R6: scrub disabled
    cyc(1'b1, 32'h8000_0000, 1'b0, 1'b0, '0, '0);
    cyc(1'b0, 0, 1'b1, 1'b0, 31'h0000_1000, 8'h01);
    check("R6 scrub disabled", {31'd0, scrub_req}, 32'h0);
    check("R5 scrub bit kept", reg_rdata, img(1'b1, 19'h1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1));
    // R6: scrub requested even when error not logged
    cyc(1'b1, 32'h0, 1'b0, 1'b0, '0, '0);
    cyc(1'b0, 0, 1'b1, 1'b0, 31'h0000_2000, 8'h02);
    check("R6 scrub while logged", {31'd0, scrub_req}, 32'h1);
    cyc(1'b1, 32'h3, 1'b0, 1'b0, '0, '0);

    // R9: check-bit forcing sweep
    for (int v = 0; v < 256; v++) begin
      for (int f = 0; f < 2; f++) begin
        @(negedge clk);
        wr_chk_in = 8'(v); force_zero = 1'(f);
        #1;
        check("R9 check bits", {24'd0, wr_chk_out}, (f == 1) ? 32'h0 : 32'(v));
      end
    end
    force_zero = 1'b0;
    finish_run();
  end
endmodule